// File: doc/BRIEF.md
# Dual-Clock Latched Serial-to-Parallel Shifter

The block turns a serial bit stream into a parallel byte. It has two clocks. Each rising edge of the shift clock moves the chain of shift stages along by one place and loads the serial input into the first stage. Each rising edge of the storage clock copies the whole shift chain into a holding register. The parallel outputs then show a stable byte while the next one is being shifted in.

The last shift stage is brought out on a serial output, so several blocks can be chained to build a wider converter. An active-low clear zeroes the shift stages at once, without waiting for a clock, and leaves the holding register alone. An active-low output enable puts the held byte on three-state parallel outputs. When the enable is high, those outputs float so that other drivers can share the lines.

Top module: `srl_shift_latch`

## Requirements
- R1: On each rising edge of `shiftClk` with `clrN` high, the value of `serIn` is loaded into shift stage 0. Stage 0 appears on `parOut[0]` after a store.
- R2: On the same edge, every stage k (1..7) takes the previous value of stage k-1. Stage 7 is the last stage and appears on `parOut[7]` after a store.
- R3: On each rising edge of `storeClk`, all eight shift stages are copied into the holding register. The holding register does not change on `shiftClk` edges.
- R4: When `shiftClk` and `storeClk` rise together, the holding register captures the shift contents from before that edge, so it always lags the shift chain by one pulse.
- R5: `serOut` always equals shift stage 7. It is not affected by `outEnN`.
- R6: While `clrN` is low, all shift stages are zero, with no clock needed, and `shiftClk` edges have no effect.
- R7: `clrN` does not alter the holding register. A store after a clear-and-release cycle still shows only what the shift chain held at that store.
- R8: After `clrN` returns high, the next rising `shiftClk` edge shifts normally.
- R9: While `outEnN` is low, `parOut` drives the holding register. While it is high, every `parOut` bit is high-impedance.
- R10: When a second block takes its `serIn` from the first block's `serOut` and shares both clocks, the pair acts as one 16-stage shifter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| shiftClk | input | 1 | Shift clock; the shift chain advances on its rising edge |
| storeClk | input | 1 | Storage clock; the holding register loads on its rising edge |
| clrN | input | 1 | Active-low asynchronous clear of the shift stages only |
| serIn | input | 1 | Serial data into stage 0 |
| outEnN | input | 1 | Active-low enable for the parallel outputs |
| serOut | output | 1 | Last shift stage, used for chaining |
| parOut | output | 8 | Three-state parallel view of the holding register |

## Verification
The assertions assume three things about the inputs. `serIn` is stable around each rising `shiftClk` edge. `clrN` changes away from clock edges. No second rising edge of a clock comes before the previous capture has settled. The driver respects all three: it changes `serIn` and `clrN` half a nanosecond or more before it raises a clock, and it gives each clock at most one pulse per bench cycle. The high-impedance state is seen through a bench-side driver on the shared parallel lines. That driver is active only while the enable is high, so a floating output reads back the bench's own pattern.

// File: rtl/srl_pkg.sv
package srl_pkg;

  // Strobes handed from the control module to the datapath
  typedef struct packed {
    logic clearShift;  // asynchronous clear of the shift stages, active high
    logic driveOut;    // enable for the parallel three-state drivers
  } srl_strobe_t;

endpackage

// File: rtl/srl_ctrl.sv
module srl_ctrl
  import srl_pkg::*;
(
  input  logic        clrN,
  input  logic        outEnN,
  output srl_strobe_t strobes
);

  // Convert the active-low pins into active-high strobes
  always_comb begin
    strobes.clearShift = ~clrN;
    strobes.driveOut   = ~outEnN;
  end

endmodule

// File: rtl/srl_datapath.sv
module srl_datapath
  import srl_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             shiftClk,
  input  logic             storeClk,
  input  logic             serIn,
  input  srl_strobe_t      strobes,
  output logic [WIDTH-1:0] shiftQ,
  output logic [WIDTH-1:0] storeQ,
  output logic             serOut,
  output wire  [WIDTH-1:0] parOut
);

  localparam int LAST = WIDTH - 1;

  logic clearLine;
  logic driveLine;

  assign clearLine = strobes.clearShift;
  assign driveLine = strobes.driveOut;

  // One flop per shift stage; stage 0 takes the serial input
  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    logic stageQ;
    logic stageD;

    if (i == 0) begin : g_head
      assign stageD = serIn;
    end else begin : g_body
      assign stageD = shiftQ[i-1];
    end

    always_ff @(posedge shiftClk or posedge clearLine) begin
      if (clearLine) stageQ <= 1'b0;
      else           stageQ <= stageD;
    end

    assign shiftQ[i] = stageQ;
  end

  // Holding register: no reset, it changes only on a storage edge
  always_ff @(posedge storeClk) begin
    storeQ <= shiftQ;
  end

  assign serOut = shiftQ[LAST];

  // Three-state drivers, one per bit
  for (genvar j = 0; j < WIDTH; j++) begin : g_drv
    assign parOut[j] = driveLine ? storeQ[j] : 1'bz;
  end

endmodule

// File: rtl/srl_shift_latch.sv
module srl_shift_latch
  import srl_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             shiftClk,
  input  logic             storeClk,
  input  logic             clrN,
  input  logic             serIn,
  input  logic             outEnN,
  output logic             serOut,
  output wire  [WIDTH-1:0] parOut
);

  srl_strobe_t      strobes;
  logic [WIDTH-1:0] shiftQ;
  logic [WIDTH-1:0] storeQ;

  srl_ctrl ctrl_i (
    .clrN    (clrN),
    .outEnN  (outEnN),
    .strobes (strobes)
  );

  srl_datapath #(.WIDTH(WIDTH)) dp_i (
    .shiftClk (shiftClk),
    .storeClk (storeClk),
    .serIn    (serIn),
    .strobes  (strobes),
    .shiftQ   (shiftQ),
    .storeQ   (storeQ),
    .serOut   (serOut),
    .parOut   (parOut)
  );

endmodule

// File: rtl/srl_shift_latch_chk.sv
module srl_shift_latch_chk #(
  parameter int WIDTH = 8
) (
  input logic             shiftClk,
  input logic             storeClk,
  input logic             clrN,
  input logic             serIn,
  input logic [WIDTH-1:0] shiftQ,
  input logic [WIDTH-1:0] storeQ
);

  // Stage 0 holds the serial input from the previous shift edge
  assert_shift_in_R1: assert property (@(posedge shiftClk) disable iff (!clrN)
    1'b1 |=> shiftQ[0] == $past(serIn));

  // Each later stage holds its neighbour's previous value
  assert_shift_advance_R2: assert property (@(posedge shiftClk) disable iff (!clrN)
    1'b1 |=> shiftQ[WIDTH-1:1] == $past(shiftQ[WIDTH-2:0]));

  // The holding register takes the shift chain as it stood at the storage edge
  assert_store_copy_R3: assert property (@(posedge storeClk) disable iff (!clrN)
    1'b1 |=> storeQ == $past(shiftQ));

  // A low clear forces every shift stage to zero (this property concerns the clear itself)
  assert_clear_zero_R6: assert property (@(posedge storeClk)
    !clrN |-> shiftQ == '0);

endmodule

bind srl_shift_latch srl_shift_latch_chk #(.WIDTH(WIDTH)) chk_i (
  .shiftClk (shiftClk),
  .storeClk (storeClk),
  .clrN     (clrN),
  .serIn    (serIn),
  .shiftQ   (shiftQ),
  .storeQ   (storeQ)
);

// File: tb/srl_shift_latch_tb.sv
`timescale 1ns/1ps
module srl_shift_latch_tb_top;

  typedef struct {
    string      tag;
    logic       serA;
    logic       serB;
    logic [7:0] parA;
    logic [7:0] parB;
  } exp_t;

  localparam logic [7:0] BENCH_PAT = 8'hA5;

  logic clk = 1'b0;
  logic shiftClk = 1'b0;
  logic storeClk = 1'b0;
  logic clrN = 1'b0;
  logic serIn = 1'b0;
  logic oeN = 1'b0;
  logic serA;
  logic serB;
  wire [7:0] parBus;
  wire [7:0] parChain;

  int testsRun = 0;
  int testsFailed = 0;
  int cycles = 0;

  exp_t expQ[$];

  // Reference model
  logic [15:0] mShift = '0;
  logic [7:0]  mStoreA = '0;
  logic [7:0]  mStoreB = '0;

  always #4 clk = ~clk;

  // While the outputs should float, the bench drives its own pattern on the lines
  assign parBus = oeN ? BENCH_PAT : 8'hzz;

  srl_shift_latch dut_i (
    .shiftClk (shiftClk),
    .storeClk (storeClk),
    .clrN     (clrN),
    .serIn    (serIn),
    .outEnN   (oeN),
    .serOut   (serA),
    .parOut   (parBus)
  );

  // Second device, chained from the first (R10)
  srl_shift_latch chain_i (
    .shiftClk (shiftClk),
    .storeClk (storeClk),
    .clrN     (clrN),
    .serIn    (serA),
    .outEnN   (1'b0),
    .serOut   (serB),
    .parOut   (parChain)
  );

  task automatic pushExp(input string tag);
    exp_t e;
    e.tag  = tag;
    e.serA = mShift[7];
    e.serB = mShift[15];
    e.parA = oeN ? BENCH_PAT : mStoreA;
    e.parB = mStoreB;
    expQ.push_back(e);
  endtask

  task automatic opShift(input logic b, input string tag);
    @(posedge clk);
    #0.5 serIn = b;
    #0.5 shiftClk = 1'b1;
    if (clrN) mShift = {mShift[14:0], b};
    #1 shiftClk = 1'b0;
    pushExp(tag);
  endtask

  task automatic opStore(input string tag);
    @(posedge clk);
    #1 storeClk = 1'b1;
    mStoreA = mShift[7:0];
    mStoreB = mShift[15:8];
    #1 storeClk = 1'b0;
    pushExp(tag);
  endtask

  task automatic opBoth(input logic b, input string tag);
    @(posedge clk);
    #0.5 serIn = b;
    #0.5 begin shiftClk = 1'b1; storeClk = 1'b1; end
    mStoreA = mShift[7:0];
    mStoreB = mShift[15:8];
    if (clrN) mShift = {mShift[14:0], b};
    #1 begin shiftClk = 1'b0; storeClk = 1'b0; end
    pushExp(tag);
  endtask

  task automatic opClr(input logic v, input string tag);
    @(posedge clk);
    #1 clrN = v;
    if (!v) mShift = '0;
    #1;
    pushExp(tag);
  endtask

  task automatic opOe(input logic v, input string tag);
    @(posedge clk);
    #1 oeN = v;
    #1;
    pushExp(tag);
  endtask

  // Monitor: pop and compare away from every edge
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      exp_t e;
      e = expQ.pop_front();
      testsRun++;
      if (serA !== e.serA || serB !== e.serB || parBus !== e.parA || parChain !== e.parB) begin
        testsFailed++;
        $display("FAIL %s: serA=%b/%b serB=%b/%b parA=%h/%h parB=%h/%h (actual/expected)",
                 e.tag, serA, e.serA, serB, e.serB, parBus, e.parA, parChain, e.parB);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      testsFailed++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected < 20000", cycles);
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    logic [7:0] patA;
    logic [7:0] patB;
    patA = 8'b1100_1010;
    patB = 8'b0011_0110;

    // Reset state: clear held, store zeros (R6, R3)
    repeat (2) @(posedge clk);
    opStore("R6 reset state");

    opClr(1'b1, "R8 release clear");
    // First byte, last bit shifted ends in stage 0 (R1, R2, R5)
    for (int i = 7; i >= 0; i--) opShift(patA[i], "R1 R2 R5 shift first byte");
    opStore("R3 store first byte");
    // Second byte pushes the first into the chained device (R10)
    for (int i = 7; i >= 0; i--) opShift(patB[i], "R10 chain shift");
    opStore("R10 chained store");

    // Shifting alone leaves the held byte unchanged (R3)
    opShift(1'b1, "R3 hold across shift");
    opShift(1'b0, "R3 hold across shift");

    // Outputs float while disabled; serial output stays live (R9, R5)
    opOe(1'b1, "R9 outputs float");
    opShift(1'b1, "R5 serial out with outputs disabled");
    opStore("R9 store while floating");
    opOe(1'b0, "R9 outputs driven again");

    // Tied clocks: holding register lags by one pulse (R4)
    for (int i = 0; i < 6; i++) opBoth(i[0] ^ i[1], "R4 tied clocks");

    // Clear during shifting (R6, R7, R8)
    opShift(1'b1, "R6 pre-clear shift");
    opClr(1'b0, "R6 clear zeros shift stages, R7 store untouched");
    opShift(1'b1, "R6 shift ignored while cleared");
    opShift(1'b1, "R6 shift ignored while cleared");
    opClr(1'b1, "R7 store still untouched after release");
    opShift(1'b1, "R8 first shift after release");
    opStore("R8 shift after release seen in store");
    opShift(1'b0, "R8 second shift after release");
    opStore("R2 advance after release");

    repeat (3) @(posedge clk);
    wait (expQ.size() == 0);
    @(posedge clk);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule